// File: doc/BRIEF.md
# Card Presence Conditioner and Shared Interrupt Driver

This block turns the raw card-presence contact of a smart card reader into a clean "card inserted" status and drives a single open-drain line that several reader devices can share toward a host. The raw contact is synchronised, interpreted through a programmable polarity, and debounced by a filter that only accepts a new level once it has been held for a programmable number of slow-tick samples. Every accepted change of the filtered state, whether an insertion or a removal, latches an insertion/extraction flag.

That flag is combined with four other latched event flags: supply settled, over-current, supply out of range and answer-to-reset timeout. The timeout only latches while automatic reset sequencing is enabled. Software may force the insertion, supply-error and timeout flags. Flags are cleared when the host acknowledges the register byte that holds them. A mode select picks what the shared line means: a flag interrupt (pulled low while any flag is pending), or a live level (released only while a card is present and neither over-current nor supply error is pending).

The register interface, the pull-up control and the analog detectors lie outside this block. It consumes their strobes and single-cycle event pulses.

Top module: `card_sense_irq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the filtered presence status, all five flags and the drive-low output are 0.
- R2: With `polHigh` = 1 a card counts as present while `presRaw` reads 1. With `polHigh` = 0 it counts as present while `presRaw` reads 0. A change of `polHigh` alone is debounced like a pin change.
- R3: `cardIn` takes a new value only after the synchronised, polarity-corrected sample has differed from it on 2^(`filtSel`+2) consecutive cycles with `tickEn` = 1. A return to the old level restarts the count, and cycles with `tickEn` = 0 do not count. With `tickEn` held at 1, `cardIn` changes SYNC_STAGES + 2^(`filtSel`+2) cycles after the pin change.
- R4: Each change of `cardIn`, in either direction, sets `insFlag` on the same clock edge.
- R5: With `modeLevel` = 0, `irqDriveLow` is 1 exactly while at least one of the five flags is set. Each hardware event pulse sets its flag one cycle later.
- R6: A pulse on `evAtrTimeout` sets `atrErrFlag` only if `autoResetEn` = 1 in that cycle. Otherwise it leaves the flag and the output unchanged.
- R7: `ackStatus` clears `supplyOkFlag` and `overCurFlag`. `ackConfig0` clears `insFlag`, `supplyErrFlag` and `atrErrFlag`. Neither strobe affects the other group.
- R8: If a set (event or software) and the clearing acknowledge of the same flag occur in the same cycle, the flag stays set.
- R9: With `modeLevel` = 1, `irqDriveLow` is 1 exactly while `cardIn` = 0, `overCurFlag` = 1 or `supplyErrFlag` = 1. The insertion, supply-settled and timeout flags do not drive it.
- R10: `swSetIns`, `swSetSupplyErr` and `swSetAtr` each set their flag one cycle later, whatever the value of `autoResetEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Slow sampling tick for the debounce filter |
| presRaw | input | 1 | Raw card-presence contact level |
| polHigh | input | 1 | Presence polarity: 1 = present when pin high |
| filtSel | input | SEL_W | Debounce length select, 2^(filtSel+2) ticks |
| modeLevel | input | 1 | Output meaning: 0 = flag interrupt, 1 = present-and-healthy level |
| autoResetEn | input | 1 | Automatic reset sequencing enabled; gates the timeout event |
| evSupplyOk | input | 1 | Pulse: card supply has settled |
| evOverCurrent | input | 1 | Pulse: over-current detected on card supply |
| evSupplyErr | input | 1 | Pulse: card supply out of range |
| evAtrTimeout | input | 1 | Pulse: no answer to reset before the clock count overflowed |
| swSetIns | input | 1 | Software force of the insertion flag |
| swSetSupplyErr | input | 1 | Software force of the supply-error flag |
| swSetAtr | input | 1 | Software force of the timeout flag |
| ackStatus | input | 1 | Host acknowledged the status byte |
| ackConfig0 | input | 1 | Host acknowledged the first configuration byte |
| cardIn | output | 1 | Filtered card-present status |
| insFlag | output | 1 | Insertion/extraction flag |
| supplyOkFlag | output | 1 | Supply-settled flag |
| overCurFlag | output | 1 | Over-current flag |
| supplyErrFlag | output | 1 | Supply out-of-range flag |
| atrErrFlag | output | 1 | Answer-to-reset timeout flag |
| irqDriveLow | output | 1 | Enable for pulling the shared open-drain line low |

## Verification
Each result has a fixed latency. Flags and the drive-low output follow an event, software set or acknowledge one cycle later. A mode change moves the output in the same cycle. A pin or polarity change reaches `cardIn` and `insFlag` after the two synchroniser stages plus the filter length, that is 6 cycles at `filtSel` = 0 and 10 at `filtSel` = 1 with the tick held high. A polarity change skips the synchroniser and takes only the filter length. The bench computes the due cycle of every expected output word when it applies the stimulus. It checks the cycle just before each filtered change as well as the change itself, so an off-by-one in the filter length is caught. A monitor samples each word at the falling edge of the due cycle, which is away from the edge where inputs change.

// File: rtl/card_sense_pkg.sv
package card_sense_pkg;

  localparam int NUM_FLAGS  = 5;
  localparam int FLG_INS    = 0;
  localparam int FLG_SUPOK  = 1;
  localparam int FLG_OVC    = 2;
  localparam int FLG_SUPERR = 3;
  localparam int FLG_ATR    = 4;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setVec;
    logic [NUM_FLAGS-1:0] clrVec;
  } flagCmd_t;

endpackage

// File: rtl/card_sense_filter.sv
module card_sense_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 3,
  parameter int BASE_SHIFT  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             presRaw,
  input  logic             polHigh,
  input  logic [SEL_W-1:0] filtSel,
  output logic             cardIn,
  output logic             cardChange
);

  localparam int MAX_EXP = (1 << SEL_W) - 1 + BASE_SHIFT;
  localparam int CNT_W   = MAX_EXP + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       holdCnt;
  logic [CNT_W-1:0]       holdLimit;
  logic                   presentNow;
  logic                   cardInQ;

  // Synchroniser chain, one flop per stage
  for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[gi] <= 1'b0;
      end else if (gi == 0) begin
        syncQ[gi] <= presRaw;
      end else begin
        syncQ[gi] <= syncQ[(gi == 0) ? 0 : gi-1];
      end
    end
  end

  always_comb begin
    presentNow = polHigh ? syncQ[SYNC_STAGES-1] : ~syncQ[SYNC_STAGES-1];
    holdLimit  = (CNT_W'(1) << (32'(filtSel) + BASE_SHIFT)) - CNT_W'(1);
    cardChange = (presentNow != cardInQ) && tickEn && (holdCnt == holdLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      cardInQ <= 1'b0;
    end else if (presentNow == cardInQ) begin
      holdCnt <= '0;
    end else if (tickEn) begin
      if (holdCnt == holdLimit) begin
        cardInQ <= presentNow;
        holdCnt <= '0;
      end else begin
        holdCnt <= holdCnt + CNT_W'(1);
      end
    end
  end

  assign cardIn = cardInQ;

  AST_FLIP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (cardInQ != $past(cardInQ)) |-> $past(tickEn)) else $error("filtered state moved without a tick"); // R3

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= holdLimit || $past(filtSel) != filtSel) else $error("debounce count beyond limit"); // R3

endmodule

// File: rtl/card_sense_ctrl.sv
module card_sense_ctrl
  import card_sense_pkg::*;
(
  input  logic     autoResetEn,
  input  logic     evSupplyOk,
  input  logic     evOverCurrent,
  input  logic     evSupplyErr,
  input  logic     evAtrTimeout,
  input  logic     swSetIns,
  input  logic     swSetSupplyErr,
  input  logic     swSetAtr,
  input  logic     ackStatus,
  input  logic     ackConfig0,
  output flagCmd_t cmd
);

  always_comb begin
    cmd = '0;
    // set requests; the insertion change itself is merged in the datapath
    cmd.setVec[FLG_INS]    = swSetIns;
    cmd.setVec[FLG_SUPOK]  = evSupplyOk;
    cmd.setVec[FLG_OVC]    = evOverCurrent;
    cmd.setVec[FLG_SUPERR] = evSupplyErr | swSetSupplyErr;
    cmd.setVec[FLG_ATR]    = (evAtrTimeout & autoResetEn) | swSetAtr;
    // clear requests follow the byte that holds each flag
    cmd.clrVec[FLG_SUPOK]  = ackStatus;
    cmd.clrVec[FLG_OVC]    = ackStatus;
    cmd.clrVec[FLG_INS]    = ackConfig0;
    cmd.clrVec[FLG_SUPERR] = ackConfig0;
    cmd.clrVec[FLG_ATR]    = ackConfig0;
  end

endmodule

// File: rtl/card_sense_dp.sv
module card_sense_dp
  import card_sense_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 3,
  parameter int BASE_SHIFT  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 presRaw,
  input  logic                 polHigh,
  input  logic [SEL_W-1:0]     filtSel,
  input  logic                 modeLevel,
  input  flagCmd_t             cmd,
  output logic                 cardIn,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irqDriveLow
);

  logic                 cardChange;
  logic [NUM_FLAGS-1:0] setAll;

  card_sense_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .SEL_W      (SEL_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_filter (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .presRaw   (presRaw),
    .polHigh   (polHigh),
    .filtSel   (filtSel),
    .cardIn    (cardIn),
    .cardChange(cardChange)
  );

  always_comb begin
    setAll          = cmd.setVec;
    setAll[FLG_INS] = cmd.setVec[FLG_INS] | cardChange;
  end

  // One latch per flag: a set beats a clear in the same cycle
  for (genvar gf = 0; gf < NUM_FLAGS; gf++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[gf] <= 1'b0;
      end else if (setAll[gf]) begin
        flags[gf] <= 1'b1;
      end else if (cmd.clrVec[gf]) begin
        flags[gf] <= 1'b0;
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      setAll[gf] |=> flags[gf]) else $error("flag lost after set"); // R8
  end

  always_comb begin
    if (modeLevel) begin
      irqDriveLow = ~cardIn | flags[FLG_OVC] | flags[FLG_SUPERR];
    end else begin
      irqDriveLow = |flags;
    end
  end

  AST_INS_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cardIn != $past(cardIn)) |-> flags[FLG_INS]) else $error("presence change without flag"); // R4

endmodule

// File: rtl/card_sense_irq.sv
module card_sense_irq
  import card_sense_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 3,
  parameter int BASE_SHIFT  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             presRaw,
  input  logic             polHigh,
  input  logic [SEL_W-1:0] filtSel,
  input  logic             modeLevel,
  input  logic             autoResetEn,
  input  logic             evSupplyOk,
  input  logic             evOverCurrent,
  input  logic             evSupplyErr,
  input  logic             evAtrTimeout,
  input  logic             swSetIns,
  input  logic             swSetSupplyErr,
  input  logic             swSetAtr,
  input  logic             ackStatus,
  input  logic             ackConfig0,
  output logic             cardIn,
  output logic             insFlag,
  output logic             supplyOkFlag,
  output logic             overCurFlag,
  output logic             supplyErrFlag,
  output logic             atrErrFlag,
  output logic             irqDriveLow
);

  flagCmd_t             flagCmd;
  logic [NUM_FLAGS-1:0] flagVec;

  card_sense_ctrl u_ctrl (
    .autoResetEn   (autoResetEn),
    .evSupplyOk    (evSupplyOk),
    .evOverCurrent (evOverCurrent),
    .evSupplyErr   (evSupplyErr),
    .evAtrTimeout  (evAtrTimeout),
    .swSetIns      (swSetIns),
    .swSetSupplyErr(swSetSupplyErr),
    .swSetAtr      (swSetAtr),
    .ackStatus     (ackStatus),
    .ackConfig0    (ackConfig0),
    .cmd           (flagCmd)
  );

  card_sense_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .SEL_W      (SEL_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .presRaw    (presRaw),
    .polHigh    (polHigh),
    .filtSel    (filtSel),
    .modeLevel  (modeLevel),
    .cmd        (flagCmd),
    .cardIn     (cardIn),
    .flags      (flagVec),
    .irqDriveLow(irqDriveLow)
  );

  assign insFlag       = flagVec[FLG_INS];
  assign supplyOkFlag  = flagVec[FLG_SUPOK];
  assign overCurFlag   = flagVec[FLG_OVC];
  assign supplyErrFlag = flagVec[FLG_SUPERR];
  assign atrErrFlag    = flagVec[FLG_ATR];

  AST_ATR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(atrErrFlag) |-> $past(autoResetEn && evAtrTimeout) || $past(swSetAtr)) else $error("timeout flag set while gated"); // R6

  AST_LEVEL_ABSENT: assert property (@(posedge clk) disable iff (!rstN)
    (modeLevel && !cardIn) |-> irqDriveLow) else $error("line released with no card"); // R9

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!modeLevel && !insFlag && !supplyOkFlag && !overCurFlag && !supplyErrFlag && !atrErrFlag) |-> !irqDriveLow) else $error("line pulled with no flag"); // R5

  AST_ACK_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (ackStatus && !evOverCurrent) |=> !overCurFlag) else $error("over-current not cleared"); // R7

endmodule

// File: tb/sim_card_sense_irq.sv
module sim_card_sense_irq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1, presRaw = 1'b0, polHigh = 1'b1;
  logic [2:0] filtSel = 3'd0;
  logic       modeLevel = 1'b0, autoResetEn = 1'b0;
  logic       evSupplyOk = 1'b0, evOverCurrent = 1'b0, evSupplyErr = 1'b0, evAtrTimeout = 1'b0;
  logic       swSetIns = 1'b0, swSetSupplyErr = 1'b0, swSetAtr = 1'b0;
  logic       ackStatus = 1'b0, ackConfig0 = 1'b0;
  logic       cardIn, insFlag, supplyOkFlag, overCurFlag, supplyErrFlag, atrErrFlag, irqDriveLow;

  always #5 clk = ~clk;

  card_sense_irq u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .presRaw(presRaw), .polHigh(polHigh),
    .filtSel(filtSel), .modeLevel(modeLevel), .autoResetEn(autoResetEn),
    .evSupplyOk(evSupplyOk), .evOverCurrent(evOverCurrent), .evSupplyErr(evSupplyErr),
    .evAtrTimeout(evAtrTimeout), .swSetIns(swSetIns), .swSetSupplyErr(swSetSupplyErr),
    .swSetAtr(swSetAtr), .ackStatus(ackStatus), .ackConfig0(ackConfig0),
    .cardIn(cardIn), .insFlag(insFlag), .supplyOkFlag(supplyOkFlag), .overCurFlag(overCurFlag),
    .supplyErrFlag(supplyErrFlag), .atrErrFlag(atrErrFlag), .irqDriveLow(irqDriveLow)
  );

  // word order: cardIn ins supOk ovc supErr atr irq
  typedef struct {
    int         due;
    logic [6:0] exp;
    string      tag;
  } item_t;

  item_t scb[$];
  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  int    idx;
  logic  finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic expectIn(int d, logic [6:0] v, string tag);
    item_t it;
    it.due = cyc + d;
    it.exp = v;
    it.tag = tag;
    scb.push_back(it);
  endtask

  // monitor: compare due items at the falling edge
  always @(negedge clk) begin
    logic [6:0] act;
    act = {cardIn, insFlag, supplyOkFlag, overCurFlag, supplyErrFlag, atrErrFlag, irqDriveLow};
    idx = 0;
    while (idx < scb.size()) begin
      if (scb[idx].due == cyc) begin
        nChecks++;
        if (act !== scb[idx].exp) begin
          nFails++;
          $display("FAIL %s cycle %0d actual %b expected %b", scb[idx].tag, cyc, act, scb[idx].exp);
        end
        scb.delete(idx);
      end else begin
        idx++;
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    expectIn(0, 7'b0000000, "R1 reset");
    expectIn(2, 7'b0000000, "R1 after reset");
    step(3);

    // R3/R4 insertion, 2 sync + 4 ticks
    presRaw = 1'b1;
    expectIn(5, 7'b0000000, "R3 one before");
    expectIn(6, 7'b1100001, "R4 insertion");
    step(8);
    ackConfig0 = 1'b1;
    expectIn(1, 7'b1000000, "R7 clear ins");
    step(); ackConfig0 = 1'b0; step(2);

    // R3 glitch of 3 samples is rejected
    presRaw = 1'b0; step(3); presRaw = 1'b1;
    expectIn(7, 7'b1000000, "R3 glitch");
    step(10);

    // R3/R4 extraction at filtSel=1, 2 sync + 8 ticks
    filtSel = 3'd1; presRaw = 1'b0;
    expectIn(9, 7'b1000000, "R3 one before");
    expectIn(10, 7'b0100001, "R4 extraction");
    step(11);
    ackConfig0 = 1'b1; expectIn(1, 7'b0000000, "R7 clear ins");
    step(); ackConfig0 = 1'b0; step(2);

    // R2 polarity flip: pin 0 now means present
    polHigh = 1'b0;
    expectIn(7, 7'b0000000, "R2 one before");
    expectIn(8, 7'b1100001, "R2 polarity");
    step(9);
    ackConfig0 = 1'b1; expectIn(1, 7'b1000000, "R7 clear ins");
    step(); ackConfig0 = 1'b0; step(2);

    // R5 supply settled, R7 wrong and right acks
    evSupplyOk = 1'b1; expectIn(1, 7'b1010001, "R5 supply settled");
    step(); evSupplyOk = 1'b0;
    ackConfig0 = 1'b1; expectIn(1, 7'b1010001, "R7 config ack keeps status flag");
    step(); ackConfig0 = 1'b0;
    ackStatus = 1'b1; expectIn(1, 7'b1000000, "R7 status ack");
    step(); ackStatus = 1'b0; step();

    // R6 timeout gating
    evAtrTimeout = 1'b1; expectIn(1, 7'b1000000, "R6 gated timeout");
    step(); evAtrTimeout = 1'b0;
    autoResetEn = 1'b1; evAtrTimeout = 1'b1;
    expectIn(1, 7'b1000011, "R6 enabled timeout");
    step(); evAtrTimeout = 1'b0; autoResetEn = 1'b0;
    ackStatus = 1'b1; expectIn(1, 7'b1000011, "R7 status ack keeps timeout");
    step(); ackStatus = 1'b0;
    ackConfig0 = 1'b1; expectIn(1, 7'b1000000, "R7 config ack");
    step(); ackConfig0 = 1'b0; step();

    // R8 set beats clear
    ackConfig0 = 1'b1; swSetIns = 1'b1;
    expectIn(1, 7'b1100001, "R8 ins set wins");
    step(); ackConfig0 = 1'b0; swSetIns = 1'b0;
    evOverCurrent = 1'b1; ackStatus = 1'b1;
    expectIn(1, 7'b1101001, "R8 ovc set wins");
    step(); evOverCurrent = 1'b0;
    ackConfig0 = 1'b1; expectIn(1, 7'b1000000, "R7 both acks");
    step(); ackStatus = 1'b0; ackConfig0 = 1'b0; step();

    // R10 software sets with auto reset off
    swSetSupplyErr = 1'b1; swSetAtr = 1'b1;
    expectIn(1, 7'b1000111, "R10 software set");
    step(); swSetSupplyErr = 1'b0; swSetAtr = 1'b0;
    ackConfig0 = 1'b1; expectIn(1, 7'b1000000, "R7 config ack");
    step(); ackConfig0 = 1'b0; step();

    // R9 level mode
    modeLevel = 1'b1; expectIn(0, 7'b1000000, "R9 healthy");
    swSetIns = 1'b1; expectIn(1, 7'b1100000, "R9 ins ignored");
    step(); swSetIns = 1'b0;
    evOverCurrent = 1'b1; expectIn(1, 7'b1101001, "R9 over-current");
    step(); evOverCurrent = 1'b0;
    ackStatus = 1'b1; expectIn(1, 7'b1100000, "R9 over-current cleared");
    step(); ackStatus = 1'b0;
    evSupplyErr = 1'b1; expectIn(1, 7'b1100101, "R9 supply error");
    step(); evSupplyErr = 1'b0;
    ackConfig0 = 1'b1; expectIn(1, 7'b1000000, "R9 supply error cleared");
    step(); ackConfig0 = 1'b0; step();
    filtSel = 3'd0; presRaw = 1'b1;
    expectIn(5, 7'b1000000, "R9 one before");
    expectIn(6, 7'b0100001, "R9 card absent");
    step(7);
    ackConfig0 = 1'b1; expectIn(1, 7'b0000001, "R9 absent holds line");
    step(); ackConfig0 = 1'b0; step();

    // R3 no counting without tick
    modeLevel = 1'b0; expectIn(0, 7'b0000000, "R5 no flags");
    tickEn = 1'b0; presRaw = 1'b0;
    expectIn(20, 7'b0000000, "R3 tick gated");
    step(20);
    tickEn = 1'b1;
    expectIn(3, 7'b0000000, "R3 one before");
    expectIn(4, 7'b1100001, "R3 tick resumes");
    step(6);

    if (scb.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard actual %0d pending expected 0", scb.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule